// File: doc/BRIEF.md
# Floating-Point Status Register with Flush-to-Zero Post-Processing

This block sits behind a floating-point datapath. It keeps the status register that governs FP exception handling and post-processes every completed operation. Each operation arrives on a valid/ready stream. The stream carries the five IEEE exception flags the datapath raised, two indications that a denormal operand or a denormal result needs special handling, and the data word in question. The block decides what the operation reports. It updates the status fields and emits one result beat that carries the possibly flushed data word and a trap flag.

When the nonstandard-mode bit is set, a denormal is not trapped. It is replaced by a zero that keeps its sign, and the inexact flag is raised. The inexact trap-enable bit can still turn that into a trap. When the bit is clear, such a case is reported as an unfinished operation instead.

Software reads the status register at any time through a plain read port. It writes the register through a write strobe. A write takes effect at the next clock edge.

Top module: `fsr_ftz_unit`

Back-pressure rules:
- An operation is accepted on a rising edge where `op_valid` and `op_ready` are both high.
- `op_ready` is high whenever the single result slot is empty or is being drained in the same cycle.
- A result beat stays on `res_data`/`res_trap` without change until `res_ready` takes it.

## Requirements
- R1: After reset the status register reads 0, `res_valid` is low and `op_ready` is high.
- R2: `op_ready` equals `!res_valid || res_ready`. Results leave in acceptance order, one per accepted operation. A stalled beat holds its data and trap flag.
- R3: With mode bit (bit 15) set, an operation flagged with a denormal operand or a denormal result gives `res_data` equal to zero with the MSB of `op_data`. Inexact (bit 0) is set in the current-exception field.
- R4: With mode bit 15 clear, a denormal-flagged operation passes `op_data` unchanged and asserts `res_trap`. The trap-type field (bits 17:16) becomes 2. The current and accrued fields do not change.
- R5: The current-exception field (bits 4:0, order invalid, overflow, underflow, divide-by-zero, inexact from bit 4 down) holds exactly the flags of the last non-unfinished operation. Flags absent from that operation are cleared.
- R6: When the flags ANDed with the trap-enable field (bits 14:10, same order) are zero, `res_trap` is low. The flags are ORed into the accrued field (bits 9:5) and the trap type is unchanged.
- R7: When that AND is nonzero, `res_trap` is high and the trap type becomes 1. The accrued field is unchanged. This covers inexact raised by a flush and enabled by bit 10.
- R8: A write loads bits 17:0 from `sw_wdata` at the next edge. It overrides the update of an operation accepted in the same cycle; that operation's result beat is still produced from the old register.
- R9: Bits 20:18 (version) and 31:21 always read 0, whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation report is valid |
| op_ready | output | 1 | Block can accept an operation report |
| op_exc | input | 5 | IEEE flags raised by the datapath |
| op_dn_opnd | input | 1 | Denormal operand needing special handling |
| op_dn_res | input | 1 | Denormal result needing special handling |
| op_data | input | 32 | Data word subject to flushing |
| res_valid | output | 1 | Result beat is valid |
| res_ready | input | 1 | Consumer takes the result beat |
| res_data | output | 32 | Possibly flushed data word |
| res_trap | output | 1 | Operation requires an FP exception trap |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Status register read value |

## Verification
A wrong register state shows up on `sw_rdata` one edge after the operation that caused it. It also shows up on the very next operation, whose trap flag depends on the enable and mode bits. A wrong flush or trap decision appears in the result beat, which a scoreboard matches against a bench model in order, under random stalls. A lost or duplicated beat surfaces as a queue mismatch when the stream drains.

// File: rtl/fsr_pkg.sv
`timescale 1ns/1ps
package fsr_pkg;
  localparam int EXC_W   = 5;
  localparam int EXC_NX  = 0;
  localparam int VER_W   = 3;
  localparam int REG_W   = 32;

  typedef enum logic [1:0] {
    FTT_NONE  = 2'd0,
    FTT_IEEE  = 2'd1,
    FTT_UNFIN = 2'd2
  } ftt_e;

  typedef struct packed {
    logic [VER_W-1:0] ver;
    ftt_e             ftt;
    logic             ns;
    logic [EXC_W-1:0] tem;
    logic [EXC_W-1:0] aexc;
    logic [EXC_W-1:0] cexc;
  } fsr_t;

  localparam int FSR_W = $bits(fsr_t);
  localparam int WR_W  = FSR_W - VER_W;
endpackage

// File: rtl/fsr_classify.sv
`timescale 1ns/1ps
module fsr_classify
  import fsr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fsr_t              cur,
  input  logic [EXC_W-1:0]  op_exc,
  input  logic              op_dn,
  input  logic [DATA_W-1:0] op_data,
  output fsr_t              nxt,
  output logic [DATA_W-1:0] res_data,
  output logic              trap
);
  logic [EXC_W-1:0] exc;

  always_comb begin
    nxt      = cur;
    res_data = op_data;
    trap     = 1'b0;
    exc      = op_exc;
    if (op_dn && !cur.ns) begin
      trap    = 1'b1;
      nxt.ftt = FTT_UNFIN;
    end else begin
      if (op_dn) begin
        res_data    = {op_data[DATA_W-1], {(DATA_W-1){1'b0}}};
        exc[EXC_NX] = 1'b1;
      end
      nxt.cexc = exc;
      if (|(exc & cur.tem)) begin
        trap    = 1'b1;
        nxt.ftt = FTT_IEEE;
      end else begin
        nxt.aexc = cur.aexc | exc;
      end
    end
  end
endmodule

// File: rtl/fsr_regfile.sv
`timescale 1ns/1ps
module fsr_regfile
  import fsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  input  logic             upd,
  input  fsr_t             nxt,
  output fsr_t             cur,
  output logic [REG_W-1:0] rdata
);
  fsr_t wr_val;
  logic unused_wbits;

  assign unused_wbits = ^wdata[REG_W-1:WR_W];

  always_comb begin
    wr_val     = fsr_t'({{VER_W{1'b0}}, wdata[WR_W-1:0]});
    wr_val.ver = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cur <= '0;
    else if (we)     cur <= wr_val;
    else if (upd)    cur <= nxt;
  end

  assign rdata = {{(REG_W-FSR_W){1'b0}}, cur};

  AST_VER_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> rdata[REG_W-1:WR_W] == '0); // R9
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> rdata[WR_W-1:0] == $past(wdata[WR_W-1:0])); // R8
endmodule

// File: rtl/fsr_out_stage.sv
`timescale 1ns/1ps
module fsr_out_stage #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_trap,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_trap
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_trap  <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= in_data;
        out_trap <= in_trap;
      end
    end
  end

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_trap))); // R2
endmodule

// File: rtl/fsr_ftz_unit.sv
`timescale 1ns/1ps
module fsr_ftz_unit
  import fsr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [EXC_W-1:0]  op_exc,
  input  logic              op_dn_opnd,
  input  logic              op_dn_res,
  input  logic [DATA_W-1:0] op_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data,
  output logic              res_trap,
  input  logic              sw_we,
  input  logic [REG_W-1:0]  sw_wdata,
  output logic [REG_W-1:0]  sw_rdata
);
  fsr_t              cur;
  fsr_t              nxt;
  logic [DATA_W-1:0] cls_data;
  logic              cls_trap;
  logic              op_dn;
  logic              fire;

  assign op_dn = op_dn_opnd | op_dn_res;
  assign fire  = op_valid && op_ready;

  fsr_classify #(.DATA_W(DATA_W)) u_cls (
    .cur(cur), .op_exc(op_exc), .op_dn(op_dn), .op_data(op_data),
    .nxt(nxt), .res_data(cls_data), .trap(cls_trap)
  );

  fsr_regfile u_reg (
    .clk(clk), .rst_n(rst_n), .we(sw_we), .wdata(sw_wdata),
    .upd(fire), .nxt(nxt), .cur(cur), .rdata(sw_rdata)
  );

  fsr_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(op_valid), .in_ready(op_ready),
    .in_data(cls_data), .in_trap(cls_trap),
    .out_valid(res_valid), .out_ready(res_ready),
    .out_data(res_data), .out_trap(res_trap)
  );

  AST_FLUSH_SIGNED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cur.ns && op_dn) |=>
      (res_valid && res_data == {$past(op_data[DATA_W-1]), {(DATA_W-1){1'b0}}})); // R3
  AST_UNFIN_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !cur.ns && op_dn && !sw_we) |=>
      (res_trap && sw_rdata[17:16] == 2'd2 && $stable(sw_rdata[9:0]))); // R4
  AST_ACCRUED_KEPT_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cls_trap && !sw_we) |=> $stable(sw_rdata[9:5])); // R7
endmodule

// File: tb/tb_fsr_ftz_unit.sv
`timescale 1ns/1ps
module tb_fsr_ftz_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [4:0]  op_exc = '0;
  logic        op_dn_opnd = 1'b0;
  logic        op_dn_res = 1'b0;
  logic [31:0] op_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [31:0] res_data;
  logic        res_trap;
  logic        sw_we = 1'b0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] sw_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  bit stall_en = 1'b0;
  int cyc = 0;

  logic [31:0] m_reg = '0;
  logic [32:0] exp_q[$];
  string       req_q[$];

  localparam logic [31:0] WMASK = 32'h0003_FFFF;

  always #2.5 clk = ~clk;

  fsr_ftz_unit dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_exc(op_exc), .op_dn_opnd(op_dn_opnd), .op_dn_res(op_dn_res),
    .op_data(op_data), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_trap(res_trap), .sw_we(sw_we),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata)
  );

  task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] r, input logic [4:0] e,
                                input logic dn, input logic [31:0] d,
                                output logic [31:0] nr, output logic [31:0] od,
                                output logic ot);
    logic [4:0] ex;
    nr = r; od = d; ot = 1'b0; ex = e;
    if (dn && !r[15]) begin
      ot = 1'b1;
      nr[17:16] = 2'd2;
    end else begin
      if (dn) begin
        od = {d[31], 31'b0};
        ex[0] = 1'b1;
      end
      nr[4:0] = ex;
      if ((ex & r[14:10]) != 5'd0) begin
        ot = 1'b1;
        nr[17:16] = 2'd1;
      end else begin
        nr[9:5] = r[9:5] | ex;
      end
    end
  endfunction

  // monitor: drives res_ready, pops and compares beats taken at the next edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      res_ready = stall_en ? (cyc % 3 == 2) : 1'b1;
      if (res_valid && res_ready) begin
        if (exp_q.size() == 0) begin
          chk("R2 unexpected beat", {res_trap, res_data}, 33'h0);
        end else begin
          logic [32:0] e;
          string rq;
          e = exp_q.pop_front();
          rq = req_q.pop_front();
          chk(rq, {res_trap, res_data}, e);
        end
      end
    end
  end

  task automatic send_op(input string req, input logic [4:0] e, input logic dno,
                         input logic dnr, input logic [31:0] d,
                         input logic with_wr, input logic [31:0] wd);
    logic [31:0] nr;
    logic [31:0] od;
    logic ot;
    @(negedge clk); #0.5;
    op_valid = 1'b1; op_exc = e; op_dn_opnd = dno; op_dn_res = dnr; op_data = d;
    while (!op_ready) begin
      @(negedge clk); #0.5;
    end
    model(m_reg, e, dno | dnr, d, nr, od, ot);
    exp_q.push_back({ot, od});
    req_q.push_back(req);
    if (with_wr) begin
      sw_we = 1'b1; sw_wdata = wd;
      m_reg = wd & WMASK;
    end else begin
      m_reg = nr;
    end
    @(posedge clk); #0.5;
    op_valid = 1'b0; sw_we = 1'b0;
  endtask

  task automatic sw_write(input logic [31:0] wd);
    @(negedge clk); #0.5;
    sw_we = 1'b1; sw_wdata = wd;
    m_reg = wd & WMASK;
    @(posedge clk); #0.5;
    sw_we = 1'b0;
  endtask

  task automatic chk_reg(input string req);
    @(negedge clk); #0.5;
    chk(req, {1'b0, sw_rdata}, {1'b0, m_reg});
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5ns * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(posedge clk);
    #0.5 rst_n = 1'b1;
    @(negedge clk); #0.5;
    chk("R1 reg", {1'b0, sw_rdata}, 33'h0);
    chk("R1 res_valid", {32'h0, res_valid}, 33'h0);
    chk("R1 op_ready", {32'h0, op_ready}, 33'h1);

    // standard mode, nothing enabled
    send_op("R6 beat underflow", 5'b00100, 0, 0, 32'h3F80_0000, 0, 0);
    chk_reg("R6 accrue underflow");
    send_op("R5 beat inexact", 5'b00001, 0, 0, 32'h4000_0000, 0, 0);
    chk_reg("R5 cexc cleared, R6 accrued ORed");

    // write with version bits set: R8, R9
    sw_write(32'hFFFC_8000);
    chk_reg("R9 version reads zero, R8 fields loaded");

    // nonstandard mode flushes
    send_op("R3 flush neg result", 5'b00000, 0, 1, 32'h8000_0123, 0, 0);
    chk_reg("R3 inexact set");
    send_op("R3 flush pos operand", 5'b00000, 1, 0, 32'h0000_0456, 0, 0);
    chk_reg("R3 operand flush reg");

    // inexact enabled, flush traps
    sw_write(32'h0000_8400);
    send_op("R7 flush inexact trap", 5'b00000, 0, 1, 32'h8000_0001, 0, 0);
    chk_reg("R7 ftt ieee, accrued kept");

    // standard mode denormal -> unfinished
    sw_write(32'h0000_0021);
    send_op("R4 unfinished beat", 5'b00010, 1, 0, 32'h0000_0777, 0, 0);
    chk_reg("R4 ftt unfinished, cexc kept");
    send_op("R6 clean op keeps ftt", 5'b00000, 0, 0, 32'h1234_5678, 0, 0);
    chk_reg("R6 ftt unchanged");

    // overflow enabled
    sw_write(32'h0000_2000);
    send_op("R7 overflow trap", 5'b01000, 0, 0, 32'h7F80_0000, 0, 0);
    chk_reg("R7 accrued unchanged");
    send_op("R6 div no trap", 5'b00010, 0, 0, 32'h7F80_0000, 0, 0);
    chk_reg("R6 div accrued");

    // collision of write and update
    send_op("R8 beat with write", 5'b10000, 0, 0, 32'hAAAA_5555, 1, 32'h0000_8000);
    chk_reg("R8 write wins");

    // burst under back-pressure
    stall_en = 1'b1;
    for (int i = 0; i < 24; i++) begin
      send_op("R2 stalled stream", 5'(i), i[0], 1'b0, 32'h8000_0000 ^ (32'(i) * 32'h0101_0101), 0, 0);
    end
    stall_en = 1'b0;
    repeat (20) @(negedge clk);
    #0.5;
    chk("R2 all beats drained", {1'b0, 32'(exp_q.size())}, 33'h0);
    chk_reg("R2 reg after burst");
    summary();
  end
endmodule